// File: doc/BRIEF.md
# Return-to-Zero Single-Bit Line Codec

This block turns single bits into return-to-zero cells on an open-drain line and turns such cells back into bits. Every cell begins with the line pulled low. The value of the bit is carried only by how long the line stays low inside a cell of fixed length, so each bit supplies its own timing reference. Two speeds are available, chosen by a mode input. The slow speed is the one in use after activation. The fast speed is used only when the surrounding control logic raises `fast_mode`.

The transmit side is a valid/ready sink. A bit is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_bit` and `fast_mode` are captured at that edge. Until acceptance the producer must hold `tx_valid` high and keep `tx_bit` stable. `tx_ready` goes high again in the last cycle of a cell, so a producer that is waiting gets back-to-back cells with no gap. The receive side passes the pin through a two-flop synchronizer. It starts counting low samples on a falling edge and classifies the count against a threshold that depends on the speed. The result is reported as a one-cycle `rx_valid` strobe. There is no back-pressure on this side, because the line cannot be stalled, so the consumer must take the strobe in the cycle it appears. While the block is transmitting, and for a short tail after, decoding is suppressed so that its own cells are never reported back.

Top module: `rz_bit_codec`

## Requirements
- R1: While `rst_n` is low, `pin_oe` is 0, `tx_ready` is 1 and `rx_valid` is 0, whatever `tx_valid` does.
- R2: At fast speed (`fast_mode`=1) a 1 is sent as a 10-cycle cell. `pin_oe`=1 (line low) for the first 2 cycles after acceptance, then 0 for the remaining 8. `tx_done` is high in the tenth cycle only.
- R3: At fast speed a 0 is sent as a 10-cycle cell with `pin_oe`=1 for 8 cycles, then 0 for 2.
- R4: At slow speed (`fast_mode`=0) a cell is 22 cycles. A 1 holds `pin_oe`=1 for 2 cycles and a 0 holds it for 20. `tx_done` is high in the twenty-second cycle only.
- R5: The speed and bit value of a cell are those captured at acceptance. Changing `fast_mode` or `tx_bit` during a cell does not alter it.
- R6: `tx_ready` is high in the final cycle of a cell. If `tx_valid` is held high, the next cell's first low cycle follows that final cycle immediately.
- R7: At fast speed a received low run of 4 samples or fewer decodes as 1. A run of 5 or more decodes as 0.
- R8: At slow speed a received low run of 8 samples or fewer decodes as 1. A run of 9 or more decodes as 0.
- R9: `rx_valid` is a single-cycle pulse. It is high in the third cycle after the clock edge that first samples `pin_in` high again, and never while the line is still low.
- R10: A low run far longer than any cell saturates the run counter without output. It then yields exactly one `rx_valid` with `rx_bit`=0 when the line rises.
- R11: The block's own transmitted cells never produce `rx_valid`. Decoding is suppressed while a cell is in flight and for three cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and cell clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | 1 selects the fast speed, 0 the slow speed |
| tx_valid | input | 1 | Transmit bit offered |
| tx_ready | output | 1 | Transmit side can take a bit this cycle |
| tx_bit | input | 1 | Bit value to encode |
| tx_done | output | 1 | High in the last cycle of a transmitted cell |
| pin_oe | output | 1 | 1 pulls the open-drain line low, 0 releases it |
| pin_in | input | 1 | Line level as seen at the pad (asynchronous) |
| rx_valid | output | 1 | One-cycle strobe: a received bit is available |
| rx_bit | output | 1 | Decoded bit, qualified by `rx_valid` |

## Verification
Transmit results are due from the first cycle after the accepting edge. `pin_oe` is low-active from then on, and `tx_done` marks the cell's last cycle. The bench therefore counts cycles from the accepting edge and expects the done flag exactly at the cell length. Receive results pass through two synchronizer flops and one output register. The bench counts edges from the one that first samples the released line and expects the strobe in the third cycle. It checks the strobe at every falling clock edge from the start of the low run, so an early, late or doubled strobe is reported.

// File: rtl/rz_pkg.sv
package rz_pkg;

  typedef enum logic {
    SPD_SLOW = 1'b0,
    SPD_FAST = 1'b1
  } rz_speed_e;

  function automatic int rz_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rz_sync.sv
module rz_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RESET_VAL;
          else        chain[g] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RESET_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/rz_tx.sv
module rz_tx
  import rz_pkg::*;
#(
  parameter int FAST_CELL  = 10,
  parameter int FAST_SHORT = 2,
  parameter int FAST_LONG  = 8,
  parameter int SLOW_CELL  = 22,
  parameter int SLOW_SHORT = 2,
  parameter int SLOW_LONG  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_mode,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic line_oe,
  output logic cell_last,
  output logic busy
);

  localparam int MAXC = rz_max(FAST_CELL, SLOW_CELL);
  localparam int CW   = $clog2(MAXC + 1);

  localparam logic [CW-1:0] F_LAST  = CW'(FAST_CELL - 1);
  localparam logic [CW-1:0] S_LAST  = CW'(SLOW_CELL - 1);
  localparam logic [CW-1:0] F_SHORT = CW'(FAST_SHORT);
  localparam logic [CW-1:0] F_LONG  = CW'(FAST_LONG);
  localparam logic [CW-1:0] S_SHORT = CW'(SLOW_SHORT);
  localparam logic [CW-1:0] S_LONG  = CW'(SLOW_LONG);

  logic            busy_q;
  logic            bit_q;
  rz_speed_e       spd_q;
  logic [CW-1:0]   pos_q;
  logic [CW-1:0]   low_len;
  logic [CW-1:0]   last_pos;
  logic            at_last;
  logic            accept;

  always_comb begin
    if (spd_q == SPD_FAST) begin
      low_len  = bit_q ? F_SHORT : F_LONG;
      last_pos = F_LAST;
    end else begin
      low_len  = bit_q ? S_SHORT : S_LONG;
      last_pos = S_LAST;
    end
  end

  assign at_last  = busy_q && (pos_q == last_pos);
  assign in_ready = !busy_q || at_last;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bit_q  <= 1'b0;
      spd_q  <= SPD_SLOW;
      pos_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      bit_q  <= in_bit;
      spd_q  <= fast_mode ? SPD_FAST : SPD_SLOW;
      pos_q  <= '0;
    end else if (at_last) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (busy_q) begin
      pos_q  <= pos_q + 1'b1;
    end
  end

  assign line_oe   = busy_q && (pos_q < low_len);
  assign cell_last = at_last;
  assign busy      = busy_q;

endmodule

// File: rtl/rz_rx.sv
module rz_rx
  import rz_pkg::*;
#(
  parameter int FAST_THRESH = 4,
  parameter int SLOW_THRESH = 8,
  parameter int MAX_CELL    = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  input  logic fast_mode,
  input  logic suppress,
  output logic out_valid,
  output logic out_bit
);

  localparam int RW = $clog2(MAX_CELL + 1) + 1;
  localparam logic [RW-1:0] SAT   = {RW{1'b1}};
  localparam logic [RW-1:0] F_THR = RW'(FAST_THRESH);
  localparam logic [RW-1:0] S_THR = RW'(SLOW_THRESH);

  logic          prev_q;
  logic          run_q;
  logic [RW-1:0] run_len;
  logic [RW-1:0] thr;
  logic          fall;

  assign fall = prev_q && !line_s;
  assign thr  = fast_mode ? F_THR : S_THR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b1;
      run_q     <= 1'b0;
      run_len   <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      prev_q    <= line_s;
      out_valid <= 1'b0;
      if (suppress) begin
        run_q   <= 1'b0;
        run_len <= '0;
      end else if (!run_q) begin
        if (fall) begin
          run_q   <= 1'b1;
          run_len <= RW'(1);
        end
      end else if (line_s) begin
        out_valid <= 1'b1;
        out_bit   <= (run_len <= thr);
        run_q     <= 1'b0;
      end else if (run_len != SAT) begin
        run_len <= run_len + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rz_bit_codec.sv
module rz_bit_codec
  import rz_pkg::*;
#(
  parameter int FAST_CELL   = 10,
  parameter int FAST_SHORT  = 2,
  parameter int FAST_LONG   = 8,
  parameter int FAST_THRESH = 4,
  parameter int SLOW_CELL   = 22,
  parameter int SLOW_SHORT  = 2,
  parameter int SLOW_LONG   = 20,
  parameter int SLOW_THRESH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_mode,
  input  logic tx_valid,
  output logic tx_ready,
  input  logic tx_bit,
  output logic tx_done,
  output logic pin_oe,
  input  logic pin_in,
  output logic rx_valid,
  output logic rx_bit
);

  localparam int MAXC = rz_max(FAST_CELL, SLOW_CELL);
  localparam int TAIL = SYNC_STAGES + 1;

  logic            line_s;
  logic            tx_busy;
  logic [TAIL-1:0] tail_q;
  logic            quiet;

  rz_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(pin_in),
    .q_sync (line_s)
  );

  rz_tx #(
    .FAST_CELL (FAST_CELL),
    .FAST_SHORT(FAST_SHORT),
    .FAST_LONG (FAST_LONG),
    .SLOW_CELL (SLOW_CELL),
    .SLOW_SHORT(SLOW_SHORT),
    .SLOW_LONG (SLOW_LONG)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fast_mode(fast_mode),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .in_bit   (tx_bit),
    .line_oe  (pin_oe),
    .cell_last(tx_done),
    .busy     (tx_busy)
  );

  // Tail covers the synchronizer latency plus the edge-detect register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tail_q <= '0;
    else        tail_q <= {tail_q[TAIL-2:0], tx_busy};
  end

  assign quiet = tx_busy || (|tail_q);

  rz_rx #(
    .FAST_THRESH(FAST_THRESH),
    .SLOW_THRESH(SLOW_THRESH),
    .MAX_CELL   (MAXC)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_s   (line_s),
    .fast_mode(fast_mode),
    .suppress (quiet),
    .out_valid(rx_valid),
    .out_bit  (rx_bit)
  );

endmodule

// File: rtl/rz_bit_codec_chk.sv
module rz_bit_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic fast_mode,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_bit,
  input logic tx_done,
  input logic pin_oe,
  input logic pin_in,
  input logic rx_valid,
  input logic rx_bit
);

  // R2, R3, R4: the line is only pulled low inside a cell, never when idle-ready
  a_r2_oe_inside_cell: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> !tx_ready)
    else $error("a_r2_oe_inside_cell");

  // R6: the final cycle of a cell offers ready
  a_r6_done_offers_ready: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> tx_ready)
    else $error("a_r6_done_offers_ready");

  // R6: ready only drops after a bit was offered
  a_r6_ready_drop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(tx_valid))
    else $error("a_r6_ready_drop_on_accept");

  // R9: receive strobe lasts one cycle
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid)
    else $error("a_r9_single_strobe");

  // R9: a strobe follows a high sample taken three edges earlier
  a_r9_strobe_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(pin_in, 3))
    else $error("a_r9_strobe_after_high");

  // R11: no decode while the block keeps driving its own cell
  a_r11_quiet_when_driving: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pin_oe) && pin_oe) |-> !rx_valid)
    else $error("a_r11_quiet_when_driving");

endmodule

bind rz_bit_codec rz_bit_codec_chk u_chk (.*);

// File: tb/rz_bit_codec_test.sv
module rz_bit_codec_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_mode = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_bit = 1'b0;
  logic pin_line = 1'b1;
  logic loopback = 1'b0;
  logic tx_ready, tx_done, pin_oe, pin_in, rx_valid, rx_bit;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  assign pin_in = loopback ? ~pin_oe : pin_line;

  rz_bit_codec uut (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit),
    .tx_done(tx_done), .pin_oe(pin_oe), .pin_in(pin_in),
    .rx_valid(rx_valid), .rx_bit(rx_bit)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Vector: {fast, is_rx, arg[7:0], exp[7:0]}
  // tx: arg = bit, exp = low cycles; rx: arg = low samples, exp = decoded bit
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'd1,  8'd2},   // R2
    {1'b1, 1'b0, 8'd0,  8'd8},   // R3
    {1'b0, 1'b0, 8'd1,  8'd2},   // R4
    {1'b0, 1'b0, 8'd0,  8'd20},  // R4
    {1'b1, 1'b1, 8'd1,  8'd1},   // R7
    {1'b1, 1'b1, 8'd2,  8'd1},   // R7
    {1'b1, 1'b1, 8'd4,  8'd1},   // R7
    {1'b1, 1'b1, 8'd5,  8'd0},   // R7
    {1'b1, 1'b1, 8'd8,  8'd0},   // R7
    {1'b0, 1'b1, 8'd2,  8'd1},   // R8
    {1'b0, 1'b1, 8'd8,  8'd1},   // R8
    {1'b0, 1'b1, 8'd9,  8'd0},   // R8
    {1'b0, 1'b1, 8'd20, 8'd0}    // R8
  };

  task automatic run_tx(input logic f, input logic b, input logic flip,
                        output int low, output int cyc);
    @(negedge clk);
    fast_mode = f; tx_bit = b; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    if (flip) begin fast_mode = ~f; tx_bit = ~b; end
    low = 0; cyc = 0;
    forever begin
      if (pin_oe) low++;
      cyc++;
      if (tx_done || cyc > 100) break;
      @(negedge clk);
    end
    fast_mode = f;
  endtask

  task automatic run_rx(input logic f, input int n, output int at, output int hits,
                        output logic b, output int early);
    @(negedge clk);
    fast_mode = f; pin_line = 1'b0; early = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (rx_valid) early++;
    end
    pin_line = 1'b1; at = 0; hits = 0; b = 1'bx;
    for (int i = 1; i <= 5; i++) begin
      @(posedge clk); @(negedge clk);
      if (rx_valid) begin
        if (at == 0) at = i;
        hits++;
        b = rx_bit;
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int low, cyc, at, hits, early, quiet_hits, pat_on, first_oe, gap_oe;
    logic b;

    // R1: reset state, with a bit offered during reset
    tx_valid = 1'b1; tx_bit = 1'b0;
    repeat (4) @(negedge clk);
    check(pin_oe == 1'b0, "R1 pin_oe in reset", pin_oe, 0);
    check(tx_ready == 1'b1, "R1 tx_ready in reset", tx_ready, 1);
    check(rx_valid == 1'b0, "R1 rx_valid in reset", rx_valid, 0);
    tx_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector walk: R2 R3 R4 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic f, is_rx;
      int arg, exp;
      f = VEC[v][17]; is_rx = VEC[v][16];
      arg = int'(VEC[v][15:8]); exp = int'(VEC[v][7:0]);
      if (!is_rx) begin
        run_tx(f, arg[0], 1'b0, low, cyc);
        check(low == exp, f ? "R2/R3 low cycles" : "R4 low cycles", low, exp);
        check(cyc == (f ? 10 : 22), f ? "R2 cell length" : "R4 cell length",
              cyc, f ? 10 : 22);
      end else begin
        run_rx(f, arg, at, hits, b, early);
        check(int'(b) == exp, f ? "R7 decoded bit" : "R8 decoded bit", int'(b), exp);
        check(at == 3 && hits == 1 && early == 0, "R9 strobe timing",
              at * 100 + hits * 10 + early, 310);
      end
      repeat (3) @(negedge clk);
    end

    // R5: speed and bit flipped mid-cell have no effect
    run_tx(1'b1, 1'b1, 1'b1, low, cyc);
    check(low == 2 && cyc == 10, "R5 fast cell kept", low * 100 + cyc, 210);
    repeat (3) @(negedge clk);
    run_tx(1'b0, 1'b0, 1'b1, low, cyc);
    check(low == 20 && cyc == 22, "R5 slow cell kept", low * 100 + cyc, 2022);
    repeat (3) @(negedge clk);

    // R6: back-to-back cells, fast 1 then fast 0
    @(negedge clk);
    fast_mode = 1'b1; tx_bit = 1'b1; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_bit = 1'b0;
    pat_on = 0; first_oe = 0; gap_oe = 1;
    for (int i = 0; i < 20; i++) begin
      if (pin_oe) pat_on++;
      if (i == 9) begin
        check(tx_ready == 1'b1 && tx_done == 1'b1, "R6 ready in last cycle",
              tx_ready, 1);
        gap_oe = pin_oe;
      end
      if (i == 10) begin
        first_oe = pin_oe;
        tx_valid = 1'b0;
      end
      @(negedge clk);
    end
    check(gap_oe == 0 && first_oe == 1, "R6 next cell starts at once",
          gap_oe * 10 + first_oe, 1);
    check(pat_on == 10, "R6 low cycles over two cells", pat_on, 10);
    repeat (3) @(negedge clk);

    // R10: very long low saturates, then decodes once as 0
    run_rx(1'b0, 150, at, hits, b, early);
    check(early == 0, "R10 no output while low", early, 0);
    check(b == 1'b0 && hits == 1, "R10 saturated run decodes 0", int'(b) * 10 + hits, 1);
    run_rx(1'b1, 100, at, hits, b, early);
    check(b == 1'b0 && at == 3, "R10 fast saturated run", int'(b) * 10 + at, 3);
    repeat (3) @(negedge clk);

    // R11: own cells looped back are not decoded
    loopback = 1'b1;
    quiet_hits = 0;
    fork
      begin
        run_tx(1'b1, 1'b0, 1'b0, low, cyc);
        run_tx(1'b0, 1'b0, 1'b0, low, cyc);
        run_tx(1'b1, 1'b1, 1'b0, low, cyc);
        repeat (6) @(negedge clk);
      end
      begin
        repeat (70) begin
          @(negedge clk);
          if (rx_valid) quiet_hits++;
        end
      end
    join
    check(quiet_hits == 0, "R11 own cells not decoded", quiet_hits, 0);
    loopback = 1'b0;
    repeat (3) @(negedge clk);

    // R7 after loopback: receiver still works
    run_rx(1'b1, 3, at, hits, b, early);
    check(b == 1'b1 && at == 3, "R7 decode after own traffic", int'(b) * 10 + at, 13);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule